// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers 32 external interrupt request lines and one internal countdown timer. It presents a single interrupt request with a hard-wired vector to a processor. Line `n` always raises vector `32 + n`, and a larger vector always wins. Each line owns a small configuration entry that holds a mask and a trigger-mode flag. Software reaches an entry indirectly: it first writes a select register, then accesses a data window register. A small register bus also exposes a task-priority register, an end-of-interrupt (EOI) strobe, the in-service register and two timer registers.

Delivery is run by a three-state machine:
- **ST_IDLE**: nothing is offered. It moves to **ST_OFFER** when a candidate becomes eligible (transition *arm*).
- **ST_OFFER**: `irq_req` is held high with the vector of the best eligible candidate. An acknowledge in this state moves the vector from pending to in-service and goes to **ST_SETTLE** (transition *take*). If the candidate stops being eligible, the machine returns to **ST_IDLE** (transition *withdraw*).
- **ST_SETTLE**: lasts one cycle, so that the new in-service state is seen before the next offer. It always returns to **ST_IDLE** (transition *rearm*).

A higher-priority request preempts the interrupt in service. Lower or equal requests wait until an EOI write retires the current interrupt.

Top module: `vic_ctrl`

## Requirements
- R1: Line n (0..31) is delivered with vector 32+n on `irq_vec`, and `irq_vec` always lies in 32..63 while `irq_req` is high.
- R2: While any interrupt is in service, a candidate is offered only if its vector is strictly greater than the highest in-service vector. Equal or lower candidates are not offered.
- R3: A lower-priority request stays pending while a higher one is in service, and it is offered once EOI writes have retired the higher ones.
- R4: A write to the EOI register (address 3) clears only the highest set in-service bit. After that, the best remaining eligible candidate is offered.
- R5: The in-service register reads at address 4 as one 32-bit word, with bit k set while vector 32+k is in service. The reset value is 0.
- R6: A write to address 0 sets the 8-bit select value, and address 0 reads that value back. Address 1 reads or writes the selected line's entry. When the select value matches no line, address 1 reads 0 and writes to it are ignored.
- R7: The select value for line n is ((n & 15) << 1) | ((n & 16) << 2). For example, line 17 uses select value 66.
- R8: Entry bit 16 is the line mask, and all 32 entries reset to 0x0001_0000 (masked). A masked line never latches an edge and is never offered.
- R9: Entry bit 15 selects the trigger mode, where 0 means edge and 1 means level. An edge line latches a rising input. A level line stays pending while its input is high, so it is offered again after an EOI if the input is still high.
- R10: The timer register at address 5 holds a mask in bit 16 and a line number in bits 3:0, and it resets to 0x0001_0000. A write of N to address 6 loads the countdown, and address 6 reads back N. When the countdown expires with the timer unmasked, the timer raises the selected line regardless of that line's own mask.
- R11: The task-priority register (address 2, 8 bits) and the timer count register both reset to 0. With nothing in service, a candidate is offered only if bits 7:4 of its vector exceed bits 7:4 of the task-priority register.
- R12: When `irq_ack` is high in a cycle where `irq_req` is high, the offered vector moves to the in-service register at that edge. `irq_req` is then low for at least the next cycle. Nothing moves to the in-service register without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | External interrupt request lines |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 8 | Vector of the offered interrupt, 0 when idle |
| irq_ack | input | 1 | Processor acknowledge, sampled while `irq_req` is high |

## Verification
The assertions assume that `irq_ack` is only meaningful while `irq_req` is high. They also assume the timer line field names a line below 16, and that the register bus presents one write per cycle with stable address and data. The stimulus drives every input at the falling edge. It raises the acknowledge only in cycles where the bench's own model predicts a request. It keeps the timer line at 5, and it issues EOI writes and line pulses as single-cycle events. A randomised phase then mixes edge, level, masked and timer sources with random acknowledge gaps and random EOI writes.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NLINE    = 32;
    localparam int LINE_W   = $clog2(NLINE);
    localparam int VEC_BASE = 32;
    localparam int ENT_MASK = 16;
    localparam int ENT_TRIG = 15;

    typedef enum logic [2:0] {
        A_SEL  = 3'd0,
        A_WIN  = 3'd1,
        A_TPR  = 3'd2,
        A_EOI  = 3'd3,
        A_ISR  = 3'd4,
        A_TLVT = 3'd5,
        A_TICR = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_SETTLE = 2'd2
    } dlv_state_e;

    // select value is a valid line index only with bits 0, 5 and 7 clear
    function automatic logic sel_valid(input logic [7:0] s);
        return (s[0] == 1'b0) && (s[5] == 1'b0) && (s[7] == 1'b0);
    endfunction

    function automatic logic [LINE_W-1:0] sel_line(input logic [7:0] s);
        return {s[6], s[4:1]};
    endfunction

endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int TMR_W = 32,
    parameter int TPR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic [NLINE-1:0]  isr,
    output logic [NLINE-1:0]  mask,
    output logic [NLINE-1:0]  trig,
    output logic [3:0]        tpr_class,
    output logic [3:0]        tmr_line,
    output logic              tmr_mask,
    output logic              icr_load,
    output logic [TMR_W-1:0]  icr_val,
    output logic              eoi_wr,
    output logic [31:0]       rdata
);

    logic [7:0]        sel_q;
    logic [TPR_W-1:0]  tpr_q;
    logic [3:0]        lvt_line_q;
    logic              lvt_mask_q;
    logic [TMR_W-1:0]  icr_q;
    logic              win_hit;
    logic [LINE_W-1:0] win_line;
    logic              win_wr;

    assign win_hit  = sel_valid(sel_q);
    assign win_line = sel_line(sel_q);
    assign win_wr   = wr && (addr == A_WIN) && win_hit;
    assign eoi_wr   = wr && (addr == A_EOI);
    assign icr_load = wr && (addr == A_TICR);
    assign icr_val  = wdata[TMR_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= '0;
            tpr_q      <= '0;
            lvt_line_q <= '0;
            lvt_mask_q <= 1'b1;
            icr_q      <= '0;
        end else if (wr) begin
            if (addr == A_SEL)  sel_q <= wdata[7:0];
            if (addr == A_TPR)  tpr_q <= wdata[TPR_W-1:0];
            if (addr == A_TICR) icr_q <= wdata[TMR_W-1:0];
            if (addr == A_TLVT) begin
                lvt_mask_q <= wdata[ENT_MASK];
                lvt_line_q <= wdata[3:0];
            end
        end
    end

    for (genvar g = 0; g < NLINE; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[g] <= 1'b1;
                trig[g] <= 1'b0;
            end else if (win_wr && (win_line == LINE_W'(g))) begin
                mask[g] <= wdata[ENT_MASK];
                trig[g] <= wdata[ENT_TRIG];
            end
        end
    end

    assign tpr_class = tpr_q[TPR_W-1 -: 4];
    assign tmr_line  = lvt_line_q;
    assign tmr_mask  = lvt_mask_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_SEL:  rdata = {24'b0, sel_q};
            A_WIN:  if (win_hit) begin
                        rdata[ENT_MASK] = mask[win_line];
                        rdata[ENT_TRIG] = trig[win_line];
                    end
            A_TPR:  rdata = 32'(tpr_q);
            A_ISR:  rdata = isr;
            A_TLVT: rdata = {15'b0, lvt_mask_q, 12'b0, lvt_line_q};
            A_TICR: rdata = 32'(icr_q);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/vic_timer.sv
module vic_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             fire
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - TMR_W'(1);
    end

    assign fire = !load && (cnt_q == TMR_W'(1));

endmodule

// File: rtl/vic_pending.sv
module vic_pending
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINE-1:0]  irq_in,
    input  logic [NLINE-1:0]  mask,
    input  logic [NLINE-1:0]  trig,
    input  logic              fire,
    input  logic              tmr_mask,
    input  logic [3:0]        tmr_line,
    input  logic              take,
    input  logic [LINE_W-1:0] take_line,
    output logic              tmr_pend,
    output logic [NLINE-1:0]  deliv
);

    logic [NLINE-1:0] prev_q;
    logic [NLINE-1:0] pend_q;
    logic             tpend_q;
    logic             tmr_taken;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (trig[g])
                pend_q[g] <= irq_in[g] & ~mask[g];
            else
                pend_q[g] <= (pend_q[g] & ~(take && (take_line == LINE_W'(g))))
                           | (irq_in[g] & ~prev_q[g] & ~mask[g]);
        end
    end

    assign tmr_taken = take && (take_line == LINE_W'(tmr_line));

    always_ff @(posedge clk) begin
        if (!rst_n) tpend_q <= 1'b0;
        else        tpend_q <= (tpend_q & ~tmr_taken) | (fire & ~tmr_mask);
    end

    assign tmr_pend = tpend_q;
    assign deliv    = (pend_q & ~mask) | (tpend_q ? (NLINE'(1) << tmr_line) : '0);

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [NLINE-1:0]  deliv,
    input  logic [NLINE-1:0]  isr,
    input  logic [3:0]        tpr_class,
    output logic [LINE_W-1:0] best,
    output logic              ok,
    output logic [LINE_W-1:0] isr_top,
    output logic              isr_any
);

    logic       cand_any;
    logic [7:0] cand_vec;

    always_comb begin
        best     = '0;
        cand_any = 1'b0;
        isr_top  = '0;
        isr_any  = 1'b0;
        for (int i = 0; i < NLINE; i++) begin
            if (deliv[i]) begin
                best     = LINE_W'(i);
                cand_any = 1'b1;
            end
            if (isr[i]) begin
                isr_top = LINE_W'(i);
                isr_any = 1'b1;
            end
        end
    end

    assign cand_vec = 8'(VEC_BASE) + 8'(best);
    assign ok = cand_any && (isr_any ? (best > isr_top) : (cand_vec[7:4] > tpr_class));

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int TMR_W = 32,
    parameter int TPR_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] irq_in,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_req,
    output logic [7:0]  irq_vec,
    input  logic        irq_ack
);

    dlv_state_e        state_q, state_d;
    logic [NLINE-1:0]  isr_q;
    logic [NLINE-1:0]  mask_w, trig_w, deliv_w;
    logic [3:0]        tpr_class_w, tmr_line_w;
    logic              tmr_mask_w, icr_load_w, eoi_w, fire_w, tmr_pend_w;
    logic [TMR_W-1:0]  icr_val_w;
    logic [LINE_W-1:0] best_w, isr_top_w;
    logic              ok_w, isr_any_w, take;

    vic_regfile #(.TMR_W(TMR_W), .TPR_W(TPR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .isr(isr_q), .mask(mask_w), .trig(trig_w), .tpr_class(tpr_class_w),
        .tmr_line(tmr_line_w), .tmr_mask(tmr_mask_w), .icr_load(icr_load_w),
        .icr_val(icr_val_w), .eoi_wr(eoi_w), .rdata(bus_rdata)
    );

    vic_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(icr_load_w), .load_val(icr_val_w), .fire(fire_w)
    );

    vic_pending u_pend (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask_w), .trig(trig_w),
        .fire(fire_w), .tmr_mask(tmr_mask_w), .tmr_line(tmr_line_w),
        .take(take), .take_line(best_w), .tmr_pend(tmr_pend_w), .deliv(deliv_w)
    );

    vic_arbiter u_arb (
        .deliv(deliv_w), .isr(isr_q), .tpr_class(tpr_class_w), .best(best_w),
        .ok(ok_w), .isr_top(isr_top_w), .isr_any(isr_any_w)
    );

    assign take = irq_req && irq_ack;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: arm, take, withdraw, rearm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ok_w) state_d = ST_OFFER;
            ST_OFFER:  if (take) state_d = ST_SETTLE;
                       else if (!ok_w) state_d = ST_IDLE;
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req = (state_q == ST_OFFER) && ok_w;
        irq_vec = irq_req ? (8'(VEC_BASE) + 8'(best_w)) : 8'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~((eoi_w && isr_any_w) ? (NLINE'(1) << isr_top_w) : '0))
                   | (take ? (NLINE'(1) << best_w) : '0);
        end
    end

endmodule

// File: rtl/vic_checks.sv
module vic_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_req,
    input logic        irq_ack,
    input logic [7:0]  irq_vec,
    input logic [31:0] isr,
    input logic [31:0] mask,
    input logic        tmr_pend,
    input logic [3:0]  tmr_line,
    input logic        eoi
);

    function automatic logic [4:0] top_bit(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) if (v[i]) r = 5'(i);
        return r;
    endfunction

    a_r1_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= 8'd32) && (irq_vec <= 8'd63));

    a_r8_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!mask[irq_vec[4:0]] || (tmr_pend && ({1'b0, tmr_line} == irq_vec[4:0]))));

    a_r2_only_higher: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (isr != 32'd0)) |-> (irq_vec[4:0] > top_bit(isr)));

    a_r12_ack_to_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> isr[$past(irq_vec[4:0])]);

    a_r12_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    a_r4_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !(irq_req && irq_ack) && (isr != 32'd0)) |=>
        ($countones(isr) == $countones($past(isr)) - 1));

endmodule

bind vic_ctrl vic_checks u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .isr(isr_q), .mask(mask_w), .tmr_pend(tmr_pend_w), .tmr_line(tmr_line_w), .eoi(eoi_w)
);

// File: tb/sim_vic_ctrl.sv
`timescale 1ns/1ps
module sim_vic_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        irq_ack = 1'b0;

    always #2 clk = ~clk;

    vic_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_ack(irq_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ack_en = 0;
    bit done = 0;

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_mask, m_trig, m_pend, m_isr, m_prev;
    bit        m_tpend, m_tmask;
    bit [7:0]  m_sel, m_tpr;
    bit [3:0]  m_tline;
    int        m_cnt, m_icr, m_state;

    function automatic int sel_of(int n);
        return ((n & 15) << 1) | ((n & 16) << 2);
    endfunction

    function automatic int top_of(bit [31:0] v);
        int r = -1;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic void m_eval(output bit ok, output int line);
        bit [31:0] d;
        int it;
        d = m_pend & ~m_mask;
        if (m_tpend) d[m_tline] = 1'b1;
        line = top_of(d);
        it = top_of(m_isr);
        if (line < 0)     ok = 0;
        else if (it >= 0) ok = (line > it);
        else              ok = (((32 + line) / 16) > (m_tpr / 16));
    endfunction

    always @(posedge clk) begin
        bit ok, take, fire;
        int line, it, wl;
        if (!rst_n) begin
            m_mask = '1; m_trig = '0; m_pend = '0; m_isr = '0; m_prev = '0;
            m_tpend = 0; m_tmask = 1; m_sel = 0; m_tpr = 0; m_tline = 0;
            m_cnt = 0; m_icr = 0; m_state = 0;
        end else begin
            m_eval(ok, line);
            take = (m_state == 1) && ok && irq_ack;
            fire = (m_cnt == 1) && !(bus_wr && bus_addr == 3'd6);
            for (int n = 0; n < 32; n++) begin
                if (m_trig[n]) m_pend[n] = irq_in[n] && !m_mask[n];
                else m_pend[n] = (m_pend[n] && !(take && line == n)) ||
                                 (irq_in[n] && !m_prev[n] && !m_mask[n]);
            end
            m_tpend = (m_tpend && !(take && line == int'(m_tline))) || (fire && !m_tmask);
            it = top_of(m_isr);
            if (bus_wr && bus_addr == 3'd3 && it >= 0) m_isr[it] = 1'b0;
            if (take) m_isr[line] = 1'b1;
            case (m_state)
                0: if (ok) m_state = 1;
                1: if (take) m_state = 2; else if (!ok) m_state = 0;
                default: m_state = 0;
            endcase
            if (bus_wr && bus_addr == 3'd6) m_cnt = int'(bus_wdata);
            else if (m_cnt != 0) m_cnt = m_cnt - 1;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_sel = bus_wdata[7:0];
                    3'd1: begin
                        wl = -1;
                        for (int n = 0; n < 32; n++) if (sel_of(n) == int'(m_sel)) wl = n;
                        if (wl >= 0) begin m_mask[wl] = bus_wdata[16]; m_trig[wl] = bus_wdata[15]; end
                    end
                    3'd2: m_tpr = bus_wdata[7:0];
                    3'd5: begin m_tmask = bus_wdata[16]; m_tline = bus_wdata[3:0]; end
                    3'd6: m_icr = int'(bus_wdata);
                    default: ;
                endcase
            end
            m_prev = irq_in;
        end
    end

    // compare on every clock, then drive acknowledge from the model
    always @(negedge clk) begin
        bit ok, er;
        int line;
        if (rst_n && !done) begin
            m_eval(ok, line);
            er = (m_state == 1) && ok;
            n_chk++;
            if (irq_req !== er) begin
                n_bad++;
                $display("FAIL R12 irq_req actual=%0b expected=%0b t=%0t", irq_req, er, $time);
            end else if (er) begin
                n_chk++;
                if (irq_vec !== 8'(32 + line)) begin
                    n_bad++;
                    $display("FAIL R1 irq_vec actual=%0d expected=%0d t=%0t", irq_vec, 32 + line, $time);
                end
            end
            irq_ack = ack_en && er;
        end else begin
            irq_ack = 1'b0;
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic set_entry(input int n, input int v);
        wr(0, sel_of(n));
        wr(1, v);
    endtask

    task automatic pulse(input int n);
        @(negedge clk); irq_in[n] = 1'b1;
        @(negedge clk); irq_in[n] = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic eoi();
        wr(3, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd_chk(4, 32'h0, "R5 isr reset");
        rd_chk(2, 32'h0, "R11 tpr reset");
        rd_chk(6, 32'h0, "R11 icr reset");
        rd_chk(5, 32'h0001_0000, "R10 lvt reset");
        for (int n = 0; n < 32; n++) begin
            wr(0, sel_of(n));
            rd_chk(1, 32'h0001_0000, "R8 entry reset masked");
        end

        // select mapping and readback
        wr(0, sel_of(17));
        rd_chk(0, 32'd66, "R7 select for line 17");
        wr(1, 32'h0000_8000);
        rd_chk(1, 32'h0000_8000, "R7 window on line 17");
        wr(1, 32'h0001_0000);
        wr(0, 1);
        rd_chk(1, 32'h0, "R6 invalid select reads zero");
        wr(1, 32'h0000_0000);
        wr(0, sel_of(0));
        rd_chk(1, 32'h0001_0000, "R6 invalid select write ignored");

        // unmask: 3,10,20 edge; 25 level
        set_entry(3, 0);
        set_entry(10, 0);
        set_entry(20, 0);
        set_entry(25, 32'h0000_8000);
        rd_chk(1, 32'h0000_8000, "R9 level flag readback");

        // no ack: nothing in service
        pulse(3); idle(3);
        rd_chk(4, 32'h0, "R12 no move without ack");
        ack_en = 1; idle(3);
        rd_chk(4, 32'h0000_0008, "R5 line 3 in service");
        pulse(10); idle(4);
        rd_chk(4, 32'h0000_0408, "R2 higher preempts");
        pulse(3); idle(4);
        rd_chk(4, 32'h0000_0408, "R2 equal does not preempt");
        eoi(); idle(4);
        rd_chk(4, 32'h0000_0008, "R4 eoi clears highest only");
        eoi(); idle(4);
        rd_chk(4, 32'h0000_0008, "R4 pending line 3 offered after eoi");
        eoi(); idle(4);
        rd_chk(4, 32'h0, "R4 all retired");

        // lower waits under higher
        pulse(20); idle(4);
        rd_chk(4, 32'h0010_0000, "R3 line 20 in service");
        pulse(10); idle(4);
        rd_chk(4, 32'h0010_0000, "R3 lower held pending");
        eoi(); idle(4);
        rd_chk(4, 32'h0000_0400, "R3 lower released by eoi");
        eoi(); idle(4);

        // task priority gating
        wr(2, 32'h30);
        pulse(20); idle(4);
        rd_chk(4, 32'h0, "R11 class 3 blocked by tpr 3");
        wr(2, 32'h20); idle(4);
        rd_chk(4, 32'h0010_0000, "R11 class 3 passes tpr 2");
        eoi(); wr(2, 0); idle(2);

        // level line
        irq_in[25] = 1'b1; idle(4);
        rd_chk(4, 32'h0200_0000, "R9 level delivered");
        eoi(); idle(4);
        rd_chk(4, 32'h0200_0000, "R9 level re-offered while high");
        irq_in[25] = 1'b0;
        eoi(); idle(4);
        rd_chk(4, 32'h0, "R9 level dropped");

        // masked line
        set_entry(3, 32'h0001_0000);
        pulse(3); idle(4);
        rd_chk(4, 32'h0, "R8 masked line ignored");

        // timer
        wr(5, 5);
        wr(6, 20); idle(30);
        rd_chk(4, 32'h0000_0020, "R10 timer raises line 5");
        rd_chk(6, 32'd20, "R10 icr readback");
        eoi(); idle(2);
        wr(5, 32'h0001_0005);
        wr(6, 10); idle(20);
        rd_chk(4, 32'h0, "R10 masked timer silent");

        // randomised phase
        set_entry(3, 0);
        wr(5, 5);
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            ack_en = ($urandom % 4) != 0;
            bus_addr = 3'd3;
            bus_wr = (($urandom % 6) == 0);
            if (($urandom % 5) == 0) irq_in[3]  = ~irq_in[3];
            if (($urandom % 7) == 0) irq_in[10] = ~irq_in[10];
            if (($urandom % 9) == 0) irq_in[20] = ~irq_in[20];
            if (($urandom % 11) == 0) irq_in[25] = ~irq_in[25];
            if (($urandom % 3) == 0) irq_in[7] = ~irq_in[7];
            if ((c % 500) == 0) begin
                bus_addr = 3'd6; bus_wdata = 32'd37; bus_wr = 1'b1;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        irq_in = '0;
        idle(10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule